// File: doc/BRIEF.md
# Display Link Bring-Up Sequencer

This block steps a display transmitter out of configuration mode into streaming mode and back again. On a start command it optionally reprograms the link. It pulses an active-high PHY reset, asks the PHY to take its new timings, and pulses an active-low core reset. It then opens the PHY stream and waits for the PHY clock to lock. After lock it hands the transmitter clock over from the pixel PLL to the PHY and enables the core and then the timing generator. A stop command undoes the streaming steps in reverse.

All waits are counted in ticks, and a tick is `CLK_PER_TICK` clock cycles. The reprogramming steps are skipped when the stored configuration is still valid. The configuration is marked stale after reset, on a timing change and on a power-down event. If the PHY does not report lock within `POLL_LIMIT` attempts, the sequencer closes the stream, raises an error and returns to idle without touching the core or the clock select.

Top module: `lnk_bringup_seq`

## Requirements
- R1: After reset: `phy_rst`=0, `core_rst_n`=1, `cfg_req`=0, `phy_stream`=0, `clk_gate`=1, `clk_sel`=0 (pixel PLL), `core_en`=0, `tg_en`=0, `busy`=0, `done`=0, `error`=0 and `cfg_dirty`=1.
- R2: On a start from idle with `cfg_dirty`=1, `phy_rst` goes high for a settle window of SETTLE_TICKS×CLK_PER_TICK cycles (plus at most one cycle). After it falls, a second settle window of the same length follows. `phy_rst` and a low `core_rst_n` are never active together.
- R3: After the PHY settle, `cfg_req` is high for exactly one cycle. `core_rst_n` falls on the next cycle and stays low for one settle window. After it rises, one more settle window passes before streaming is requested.
- R4: A start with `cfg_dirty`=0 produces no PHY reset, no core reset and no `cfg_req`. `cfg_dirty` clears when the core-reset settle window ends. A pulse on `cfg_update` or `pwr_down` sets it again, and a set wins over a clear in the same cycle.
- R5: `phy_stream` rises when polling begins. `phy_ready` is sampled in the first poll cycle and again every CLK_PER_TICK cycles after that, for at most POLL_LIMIT samples. The clock gate drops on the cycle after the sample that sees `phy_ready`=1.
- R6: If none of the POLL_LIMIT samples sees `phy_ready`, the sequencer does the following: `phy_stream` falls (POLL_LIMIT−1)×CLK_PER_TICK+1 cycles after it rose, `error` becomes 1, `core_en`, `tg_en` and `clk_sel` stay 0, and the block returns to idle. `error` clears on the next accepted start.
- R7: Bring-up handover runs one step per cycle: `clk_gate` falls, then `clk_sel` goes to 1 (PHY source), then `clk_gate` rises, then `core_en` rises, then `tg_en` rises. `clk_sel` changes only while `clk_gate`=0.
- R8: `done`=1 exactly while streaming with core and timing generator enabled; it rises in the cycle that `tg_en` rises. `busy`=1 in every transitional state, and `busy` and `done` are never both 1.
- R9: On stop from streaming, one step per cycle: `core_en` falls, then `tg_en` falls, then `clk_gate` falls, then `clk_sel` returns to 0, then `clk_gate` rises, then `phy_stream` falls and the block is idle.
- R10: A start while busy or streaming has no effect. A stop anywhere except the streaming state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to enter streaming mode |
| stop_req | input | 1 | Request to leave streaming mode |
| cfg_update | input | 1 | New timings selected; marks configuration stale |
| pwr_down | input | 1 | Power-down event; marks configuration stale |
| phy_ready | input | 1 | PHY clock locked |
| phy_rst | output | 1 | PHY reset, active high |
| core_rst_n | output | 1 | Transmitter core reset, active low |
| cfg_req | output | 1 | One-cycle request for the PHY to load timings |
| phy_stream | output | 1 | PHY stream enable |
| clk_gate | output | 1 | Transmitter clock enable |
| clk_sel | output | 1 | Transmitter clock source: 0 pixel PLL, 1 PHY |
| core_en | output | 1 | Transmitter core enable |
| tg_en | output | 1 | Timing generator enable |
| cfg_dirty | output | 1 | Configuration must be reapplied on next start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Streaming fully enabled |
| error | output | 1 | Last start failed waiting for PHY lock |

## Verification
The bench builds the block with CLK_PER_TICK=4, SETTLE_TICKS=3 and POLL_LIMIT=5. With these values each settle window is about a dozen cycles and the full lock timeout is under twenty. Exact window widths, the five-sample poll cadence, a lock found on the second sample and a complete timeout can all be measured cycle by cycle in a short run. These small values also let stop and start commands be injected in the middle of a reset window.

// File: rtl/lnk_seq_pkg.sv
package lnk_seq_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PRST_ON,
        S_PRST_OFF,
        S_CFG,
        S_CRST_ON,
        S_CRST_OFF,
        S_POLL,
        S_UP_SEL,
        S_UP_UNGATE,
        S_UP_CORE,
        S_UP_TG,
        S_LIVE,
        S_DN_TG,
        S_DN_GATE,
        S_DN_SEL,
        S_DN_UNGATE,
        S_DN_STREAM
    } lnk_state_e;

    typedef struct packed {
        logic phy_rst;
        logic core_rst_n;
        logic cfg_req;
        logic phy_stream;
        logic clk_gate;
        logic clk_sel;
        logic core_en;
        logic tg_en;
    } lnk_ctl_t;

    localparam logic CLK_SRC_PIXEL = 1'b0;
    localparam logic CLK_SRC_PHY   = 1'b1;

    localparam lnk_ctl_t CTL_RESET = '{
        phy_rst:    1'b0,
        core_rst_n: 1'b1,
        cfg_req:    1'b0,
        phy_stream: 1'b0,
        clk_gate:   1'b1,
        clk_sel:    CLK_SRC_PIXEL,
        core_en:    1'b0,
        tg_en:      1'b0
    };

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/lnk_tick_prescale.sv
module lnk_tick_prescale #(
    parameter int unsigned CLK_PER_TICK = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic wrap,
    output logic phase0
);
    localparam int unsigned PW = lnk_seq_pkg::bits_for(CLK_PER_TICK - 1);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

    logic [PW-1:0] cnt_q;

    assign wrap   = run && (cnt_q == LAST);
    assign phase0 = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_wait_timer.sv
module lnk_wait_timer #(
    parameter int unsigned CLK_PER_TICK = 100000,
    parameter int unsigned TW           = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired,
    output logic          phase0
);
    logic [TW-1:0] rem_q;
    logic          run;
    logic          wrap;

    assign run     = (rem_q != '0);
    assign expired = !run;

    lnk_tick_prescale #(.CLK_PER_TICK(CLK_PER_TICK)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (load),
        .run    (run),
        .wrap   (wrap),
        .phase0 (phase0)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (wrap) begin
            rem_q <= rem_q - 1'b1;
        end
    end
endmodule

// File: rtl/lnk_dirty_flag.sv
module lnk_dirty_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic dirty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= 1'b1;
        end else if (set) begin
            dirty <= 1'b1;
        end else if (clr) begin
            dirty <= 1'b0;
        end
    end
endmodule

// File: rtl/lnk_bringup_seq.sv
module lnk_bringup_seq #(
    parameter int unsigned CLK_PER_TICK = 100000,
    parameter int unsigned SETTLE_TICKS = 10,
    parameter int unsigned POLL_LIMIT   = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic stop_req,
    input  logic cfg_update,
    input  logic pwr_down,
    input  logic phy_ready,
    output logic phy_rst,
    output logic core_rst_n,
    output logic cfg_req,
    output logic phy_stream,
    output logic clk_gate,
    output logic clk_sel,
    output logic core_en,
    output logic tg_en,
    output logic cfg_dirty,
    output logic busy,
    output logic done,
    output logic error
);
    import lnk_seq_pkg::*;

    localparam int unsigned TMAX = max_u(SETTLE_TICKS, POLL_LIMIT);
    localparam int unsigned TW   = bits_for(TMAX);
    localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_TICKS);
    localparam logic [TW-1:0] POLL_V   = TW'(POLL_LIMIT - 1);

    lnk_state_e    st_q, st_d;
    lnk_ctl_t      ctl_q, ctl_d;
    logic          err_q, err_d;
    logic          ld;
    logic [TW-1:0] ld_val;
    logic          t_exp;
    logic          t_ph0;
    logic          dirty_clr;

    lnk_wait_timer #(.CLK_PER_TICK(CLK_PER_TICK), .TW(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (t_exp),
        .phase0   (t_ph0)
    );

    lnk_dirty_flag u_dirty (
        .clk   (clk),
        .rst   (rst),
        .set   (cfg_update | pwr_down),
        .clr   (dirty_clr),
        .dirty (cfg_dirty)
    );

    always_comb begin
        st_d          = st_q;
        ctl_d         = ctl_q;
        ctl_d.cfg_req = 1'b0;
        err_d         = err_q;
        ld            = 1'b0;
        ld_val        = '0;
        dirty_clr     = 1'b0;
        case (st_q)
            S_IDLE: if (start_req) begin
                err_d = 1'b0;
                ld    = 1'b1;
                if (cfg_dirty) begin
                    ctl_d.phy_rst = 1'b1;
                    ld_val        = SETTLE_V;
                    st_d          = S_PRST_ON;
                end else begin
                    ctl_d.phy_stream = 1'b1;
                    ld_val           = POLL_V;
                    st_d             = S_POLL;
                end
            end
            S_PRST_ON: if (t_exp) begin
                ctl_d.phy_rst = 1'b0;
                ld            = 1'b1;
                ld_val        = SETTLE_V;
                st_d          = S_PRST_OFF;
            end
            S_PRST_OFF: if (t_exp) begin
                ctl_d.cfg_req = 1'b1;
                st_d          = S_CFG;
            end
            S_CFG: begin
                ctl_d.core_rst_n = 1'b0;
                ld               = 1'b1;
                ld_val           = SETTLE_V;
                st_d             = S_CRST_ON;
            end
            S_CRST_ON: if (t_exp) begin
                ctl_d.core_rst_n = 1'b1;
                ld               = 1'b1;
                ld_val           = SETTLE_V;
                st_d             = S_CRST_OFF;
            end
            S_CRST_OFF: if (t_exp) begin
                dirty_clr        = 1'b1;
                ctl_d.phy_stream = 1'b1;
                ld               = 1'b1;
                ld_val           = POLL_V;
                st_d             = S_POLL;
            end
            S_POLL: if (t_ph0) begin
                if (phy_ready) begin
                    ctl_d.clk_gate = 1'b0;
                    st_d           = S_UP_SEL;
                end else if (t_exp) begin
                    ctl_d.phy_stream = 1'b0;
                    err_d            = 1'b1;
                    st_d             = S_IDLE;
                end
            end
            S_UP_SEL: begin
                ctl_d.clk_sel = CLK_SRC_PHY;
                st_d          = S_UP_UNGATE;
            end
            S_UP_UNGATE: begin
                ctl_d.clk_gate = 1'b1;
                st_d           = S_UP_CORE;
            end
            S_UP_CORE: begin
                ctl_d.core_en = 1'b1;
                st_d          = S_UP_TG;
            end
            S_UP_TG: begin
                ctl_d.tg_en = 1'b1;
                st_d        = S_LIVE;
            end
            S_LIVE: if (stop_req) begin
                ctl_d.core_en = 1'b0;
                st_d          = S_DN_TG;
            end
            S_DN_TG: begin
                ctl_d.tg_en = 1'b0;
                st_d        = S_DN_GATE;
            end
            S_DN_GATE: begin
                ctl_d.clk_gate = 1'b0;
                st_d           = S_DN_SEL;
            end
            S_DN_SEL: begin
                ctl_d.clk_sel = CLK_SRC_PIXEL;
                st_d          = S_DN_UNGATE;
            end
            S_DN_UNGATE: begin
                ctl_d.clk_gate = 1'b1;
                st_d           = S_DN_STREAM;
            end
            S_DN_STREAM: begin
                ctl_d.phy_stream = 1'b0;
                st_d             = S_IDLE;
            end
            default: begin
                ctl_d = CTL_RESET;
                st_d  = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            ctl_q <= CTL_RESET;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ctl_q <= ctl_d;
            err_q <= err_d;
        end
    end

    assign phy_rst    = ctl_q.phy_rst;
    assign core_rst_n = ctl_q.core_rst_n;
    assign cfg_req    = ctl_q.cfg_req;
    assign phy_stream = ctl_q.phy_stream;
    assign clk_gate   = ctl_q.clk_gate;
    assign clk_sel    = ctl_q.clk_sel;
    assign core_en    = ctl_q.core_en;
    assign tg_en      = ctl_q.tg_en;
    assign error      = err_q;
    assign done       = (st_q == S_LIVE);
    assign busy       = (st_q != S_IDLE) && (st_q != S_LIVE);
endmodule

// File: rtl/lnk_bringup_seq_chk.sv
module lnk_bringup_seq_chk (
    input logic clk,
    input logic rst,
    input logic phy_rst,
    input logic core_rst_n,
    input logic cfg_req,
    input logic phy_stream,
    input logic clk_gate,
    input logic clk_sel,
    input logic core_en,
    input logic tg_en,
    input logic busy,
    input logic done,
    input logic error
);
    assert_rst_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(phy_rst && !core_rst_n));

    assert_cfg_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_req |=> !cfg_req);

    assert_cfg_in_config_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> !phy_stream && core_rst_n && !phy_rst);

    assert_fail_clean_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> !phy_stream && !core_en && !tg_en && !clk_sel);

    assert_core_after_clock_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(core_en) |-> clk_sel && clk_gate && phy_stream);

    assert_tg_after_core_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tg_en) |-> core_en);

    assert_sel_while_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_sel) |-> !clk_gate);

    assert_done_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> phy_stream && core_en && tg_en && clk_sel && clk_gate);

    assert_busy_done_R8: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_stop_unwound_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_stream) |-> !core_en && !tg_en && !clk_sel && clk_gate);
endmodule

bind lnk_bringup_seq lnk_bringup_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .phy_rst    (phy_rst),
    .core_rst_n (core_rst_n),
    .cfg_req    (cfg_req),
    .phy_stream (phy_stream),
    .clk_gate   (clk_gate),
    .clk_sel    (clk_sel),
    .core_en    (core_en),
    .tg_en      (tg_en),
    .busy       (busy),
    .done       (done),
    .error      (error)
);

// File: tb/lnk_bringup_seq_test.sv
module lnk_bringup_seq_test;
    localparam int CPT = 4;
    localparam int ST  = 3;
    localparam int PL  = 5;
    localparam int WIN = ST * CPT;
    localparam int TMO = (PL - 1) * CPT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, stop_req = 1'b0, cfg_update = 1'b0, pwr_down = 1'b0;
    logic phy_ready = 1'b0;
    logic phy_rst, core_rst_n, cfg_req, phy_stream, clk_gate, clk_sel;
    logic core_en, tg_en, cfg_dirty, busy, done, error;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    lnk_bringup_seq #(.CLK_PER_TICK(CPT), .SETTLE_TICKS(ST), .POLL_LIMIT(PL)) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
        .cfg_update(cfg_update), .pwr_down(pwr_down), .phy_ready(phy_ready),
        .phy_rst(phy_rst), .core_rst_n(core_rst_n), .cfg_req(cfg_req),
        .phy_stream(phy_stream), .clk_gate(clk_gate), .clk_sel(clk_sel),
        .core_en(core_en), .tg_en(tg_en), .cfg_dirty(cfg_dirty),
        .busy(busy), .done(done), .error(error)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // edge marks, sampled at the falling clock edge
    int t_prst_r, t_prst_f, t_cfg, n_cfg, n_cfg_hi, t_crst_f, t_crst_r;
    int t_strm_r, t_strm_f, t_gate_f, t_gate_r, t_sel_r, t_sel_f;
    int t_core_r, t_core_f, t_tg_r, t_tg_f, t_done_r, n_prst, n_busy;
    logic p_prst, p_cfg, p_crst, p_strm, p_gate, p_sel, p_core, p_tg, p_done;

    task automatic clear_marks();
        t_prst_r = -1; t_prst_f = -1; t_cfg = -1; n_cfg = 0; n_cfg_hi = 0;
        t_crst_f = -1; t_crst_r = -1; t_strm_r = -1; t_strm_f = -1;
        t_gate_f = -1; t_gate_r = -1; t_sel_r = -1; t_sel_f = -1;
        t_core_r = -1; t_core_f = -1; t_tg_r = -1; t_tg_f = -1;
        t_done_r = -1; n_prst = 0; n_busy = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (phy_rst && !p_prst) begin t_prst_r = cyc; n_prst++; end
            if (!phy_rst && p_prst) t_prst_f = cyc;
            if (cfg_req && !p_cfg) begin t_cfg = cyc; n_cfg++; end
            if (cfg_req) n_cfg_hi++;
            if (!core_rst_n && p_crst) t_crst_f = cyc;
            if (core_rst_n && !p_crst) t_crst_r = cyc;
            if (phy_stream && !p_strm) t_strm_r = cyc;
            if (!phy_stream && p_strm) t_strm_f = cyc;
            if (!clk_gate && p_gate) t_gate_f = cyc;
            if (clk_gate && !p_gate) t_gate_r = cyc;
            if (clk_sel && !p_sel) t_sel_r = cyc;
            if (!clk_sel && p_sel) t_sel_f = cyc;
            if (core_en && !p_core) t_core_r = cyc;
            if (!core_en && p_core) t_core_f = cyc;
            if (tg_en && !p_tg) t_tg_r = cyc;
            if (!tg_en && p_tg) t_tg_f = cyc;
            if (done && !p_done) t_done_r = cyc;
            if (busy) n_busy++;
        end
        p_prst = phy_rst; p_cfg = cfg_req; p_crst = core_rst_n; p_strm = phy_stream;
        p_gate = clk_gate; p_sel = clk_sel; p_core = core_en; p_tg = tg_en; p_done = done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        chk(act >= lo && act <= hi, req, act, lo);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
    endtask

    task automatic wait_quiet();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(phy_rst == 0 && core_rst_n == 1 && cfg_req == 0, "R1 resets idle", {phy_rst, core_rst_n, cfg_req}, 3'b010);
        chk(phy_stream == 0 && clk_gate == 1 && clk_sel == 0, "R1 clock idle", {phy_stream, clk_gate, clk_sel}, 3'b010);
        chk(core_en == 0 && tg_en == 0, "R1 enables off", {core_en, tg_en}, 0);
        chk(busy == 0 && done == 0 && error == 0, "R1 status", {busy, done, error}, 0);
        chk(cfg_dirty == 1, "R1 dirty after reset", cfg_dirty, 1);
    endtask

    task automatic test_dirty_start();
        phy_ready = 1'b0;
        clear_marks();
        pulse_start();
        while (!phy_stream) @(negedge clk);
        repeat (2) @(negedge clk);
        phy_ready = 1'b1;
        wait_quiet();
        chk_rng("R2 phy reset width", t_prst_f - t_prst_r, WIN, WIN + 1);
        chk_rng("R2 phy settle", t_cfg - t_prst_f, WIN, WIN + 1);
        chk(n_cfg == 1 && n_cfg_hi == 1, "R3 cfg_req one cycle", n_cfg_hi, 1);
        chk(t_crst_f - t_cfg == 1, "R3 core reset follows cfg", t_crst_f - t_cfg, 1);
        chk_rng("R3 core reset width", t_crst_r - t_crst_f, WIN, WIN + 1);
        chk_rng("R3 core settle", t_strm_r - t_crst_r, WIN, WIN + 1);
        chk(cfg_dirty == 0, "R4 dirty cleared", cfg_dirty, 0);
        chk(t_gate_f - t_strm_r == CPT + 1, "R5 ready on second sample", t_gate_f - t_strm_r, CPT + 1);
        chk(t_sel_r - t_gate_f == 1, "R7 select after gate off", t_sel_r - t_gate_f, 1);
        chk(t_gate_r - t_sel_r == 1, "R7 ungate after select", t_gate_r - t_sel_r, 1);
        chk(t_core_r - t_gate_r == 1, "R7 core after ungate", t_core_r - t_gate_r, 1);
        chk(t_tg_r - t_core_r == 1, "R7 tg after core", t_tg_r - t_core_r, 1);
        chk(done == 1 && busy == 0 && t_done_r == t_tg_r, "R8 done with tg", t_done_r, t_tg_r);
        chk(n_busy > 0, "R8 busy during bring-up", n_busy, 1);
    endtask

    task automatic test_stop();
        clear_marks();
        pulse_stop();
        wait_quiet();
        chk(t_tg_f - t_core_f == 1, "R9 tg off after core", t_tg_f - t_core_f, 1);
        chk(t_gate_f - t_tg_f == 1, "R9 gate off after tg", t_gate_f - t_tg_f, 1);
        chk(t_sel_f - t_gate_f == 1, "R9 select back to pixel", t_sel_f - t_gate_f, 1);
        chk(t_gate_r - t_sel_f == 1, "R9 ungate after select", t_gate_r - t_sel_f, 1);
        chk(t_strm_f - t_gate_r == 1, "R9 stream off last", t_strm_f - t_gate_r, 1);
        chk(done == 0 && busy == 0 && clk_sel == 0 && clk_gate == 1, "R9 idle after stop",
            {done, busy, clk_sel, clk_gate}, 4'b0001);
    endtask

    task automatic test_clean_start();
        phy_ready = 1'b1;
        clear_marks();
        pulse_start();
        wait_quiet();
        chk(n_prst == 0 && t_crst_f == -1, "R4 no resets when clean", n_prst, 0);
        chk(n_cfg == 0, "R4 no cfg_req when clean", n_cfg, 0);
        chk(t_gate_f - t_strm_r == 1, "R5 ready on first sample", t_gate_f - t_strm_r, 1);
        chk(done == 1, "R8 streaming after clean start", done, 1);
    endtask

    task automatic test_ignored_cmds();
        clear_marks();
        pulse_start();
        repeat (4) @(negedge clk);
        chk(n_prst == 0 && t_strm_f == -1 && done == 1, "R10 start while live", n_prst, 0);
        pulse_stop();
        wait_quiet();
        @(negedge clk) pwr_down = 1'b1;
        @(negedge clk) pwr_down = 1'b0;
        chk(cfg_dirty == 1, "R4 power-down marks dirty", cfg_dirty, 1);
        clear_marks();
        pulse_start();
        repeat (3) @(negedge clk);
        chk(busy == 1, "R8 busy during reset window", busy, 1);
        pulse_stop();
        pulse_start();
        wait_quiet();
        chk(n_prst == 1 && n_cfg == 1, "R10 commands ignored while busy", n_prst, 1);
        chk(done == 1 && t_core_f == -1, "R10 stop ignored while busy", done, 1);
        pulse_stop();
        wait_quiet();
        @(negedge clk) cfg_update = 1'b1;
        @(negedge clk) cfg_update = 1'b0;
        chk(cfg_dirty == 1, "R4 timing update marks dirty", cfg_dirty, 1);
    endtask

    task automatic test_timeout();
        phy_ready = 1'b1;
        pulse_start();
        wait_quiet();
        pulse_stop();
        wait_quiet();
        phy_ready = 1'b0;
        clear_marks();
        pulse_start();
        wait_quiet();
        chk(error == 1 && done == 0, "R6 error raised", error, 1);
        chk(phy_stream == 0 && busy == 0, "R6 stream closed", phy_stream, 0);
        chk_rng("R6 timeout length", t_strm_f - t_strm_r, TMO, TMO + 2);
        chk(t_core_r == -1 && t_tg_r == -1 && t_sel_r == -1, "R6 core untouched", t_core_r, -1);
        chk(t_gate_f == -1, "R5 no handover without ready", t_gate_f, -1);
        phy_ready = 1'b1;
        clear_marks();
        pulse_start();
        chk(error == 0, "R6 error cleared on start", error, 0);
        wait_quiet();
        chk(done == 1 && error == 0, "R6 retry succeeds", done, 1);
        pulse_stop();
        wait_quiet();
    endtask

    initial begin
        clear_marks();
        test_reset();
        test_dirty_start();
        test_stop();
        test_clean_start();
        test_ignored_cmds();
        test_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (R1..R10 sequence hung): actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule